// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a two-way set-associative read cache that tries to reach the speed of a direct-mapped lookup. Each set keeps one prediction bit naming the way it expects the next access to use. When a request arrives, that bit steers the data multiplexer at once. The stored tag of that way alone goes through a single comparator in the same cycle. A correct guess returns the word one cycle after the request is accepted.

When the guess is wrong, the cache stalls the requester for one cycle and compares the other way. A match there is a two-cycle hit, and the response flags it. When neither way matches, the access is a true miss. The cache then raises a refill request on a simple memory port and holds it until the memory acknowledges. It writes the returned word into the victim way that a per-set LRU bit names, and forwards the word to the requester.

Each line holds one word. Requests are read-only, and only one access is in flight at a time.

Top module: `wp_cache`

## Requirements
- R1: After reset every line is invalid and every prediction names way 0. stall_o, resp_valid_o and mem_req_o are low, and the first access to any address is a true miss.
- R2: A request is accepted when req_valid_i is high and stall_o is low. If the predicted way holds the address, resp_valid_o is high in the cycle after acceptance with resp_slow_o=0 and resp_miss_o=0, and stall_o stays low.
- R3: If the predicted way misses but the other way holds the address, stall_o is high for exactly one cycle after acceptance. The response then comes two cycles after acceptance with resp_slow_o=1 and resp_miss_o=0.
- R4: If neither way holds the address, mem_req_o rises two cycles after acceptance with mem_addr_o equal to the request address. Both stay steady until mem_ack_i. The response follows one cycle after the ack with resp_miss_o=1, resp_slow_o=0 and the data from mem_data_i.
- R5: After a two-cycle hit, the set's prediction names the way that hit, so an immediate repeat of that address is a one-cycle hit.
- R6: After a refill, the set's prediction names the filled way, so an immediate repeat of that address is a one-cycle hit.
- R7: Each set holds one LRU bit that every hit and refill updates to name the other way. A refill replaces the way that LRU bit names.
- R8: resp_data_o always equals the word that memory holds for the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | ADDR_W | Word address of the request |
| stall_o | output | 1 | High while the cache cannot accept a request |
| resp_valid_o | output | 1 | Response data valid |
| resp_data_o | output | DATA_W | Read data |
| resp_slow_o | output | 1 | Response was a hit found in the second cycle |
| resp_miss_o | output | 1 | Response came from a refill |
| mem_req_o | output | 1 | Refill request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Refill word address |
| mem_ack_i | input | 1 | Refill data valid |
| mem_data_i | input | DATA_W | Refill data |

## Verification
Assertions check the following on every cycle:
- a first-cycle tag match yields a fast response in the next cycle;
- a first-cycle mismatch stalls the requester;
- the fallback probe lasts a single cycle;
- a pending refill request keeps a steady address;
- a miss response always follows an ack.

Only the bench scenarios can show that the prediction and LRU bits steer later accesses correctly. The bench does this by repeating addresses after slow hits and refills, and by forcing three tags into one set so that a replaced line later misses. Its reference model also predicts fast, slow or miss latency and data for a long random run confined to two sets.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALT,
    ST_FILL
  } wp_state_e;
endpackage

// File: rtl/wp_tag_array.sv
module wp_tag_array #(
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [IDX_W-1:0]                  rd_idx_i,
  output logic [wp_pkg::WAYS-1:0][TAG_W-1:0] rd_tag_o,
  output logic [wp_pkg::WAYS-1:0]           rd_vld_o,
  input  logic                              wr_en_i,
  input  logic                              wr_way_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [TAG_W-1:0]                  wr_tag_i
);
  for (genvar w = 0; w < wp_pkg::WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic             sel;

    assign sel = wr_en_i && (wr_way_i == 1'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= '0;
      else if (sel) vld_q[wr_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) tag_q[wr_idx_i] <= wr_tag_i;
    end

    assign rd_tag_o[w] = tag_q[rd_idx_i];
    assign rd_vld_o[w] = vld_q[rd_idx_i];
  end
endmodule

// File: rtl/wp_data_array.sv
module wp_data_array #(
  parameter int SETS   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              rd_way_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic              wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [wp_pkg::WAYS-1:0][DATA_W-1:0] way_data;

  for (genvar w = 0; w < wp_pkg::WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [SETS];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_way_i == 1'(w))) mem_q[wr_idx_i] <= wr_data_i;
    end

    assign way_data[w] = mem_q[rd_idx_i];
  end

  // Mux steered by the prediction, ahead of the tag compare
  assign rd_data_o = way_data[rd_way_i];
endmodule

// File: rtl/wp_pred.sv
module wp_pred #(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             pred_way_o,
  output logic             lru_way_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_way_i
);
  logic [SETS-1:0] pred_q;
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= '0;
      lru_q  <= '0;
    end else if (upd_en_i) begin
      pred_q[upd_idx_i] <= upd_way_i;
      lru_q[upd_idx_i]  <= ~upd_way_i;
    end
  end

  assign pred_way_o = pred_q[rd_idx_i];
  assign lru_way_o  = lru_q[rd_idx_i];
endmodule

// File: rtl/wp_cache.sv
module wp_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              stall_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              resp_slow_o,
  output logic              resp_miss_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  import wp_pkg::*;

  wp_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              alt_q, victim_q;
  logic              rv_q, slow_q, miss_q;
  logic [DATA_W-1:0] rdata_q;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              pred_way, lru_way, probe_way;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0]   rd_vld;
  logic [TAG_W-1:0]  sel_tag;
  logic              probe_hit;
  logic [DATA_W-1:0] rd_data;
  logic              accept, fill_done, upd_en, upd_way;

  assign lk_addr   = (state_q == ST_IDLE) ? req_addr_i : addr_q;
  assign lk_idx    = lk_addr[IDX_W-1:0];
  assign lk_tag    = lk_addr[ADDR_W-1:IDX_W];
  assign probe_way = (state_q == ST_IDLE) ? pred_way : alt_q;

  // Single comparator: only the probed way's tag is checked
  assign sel_tag   = rd_tag[probe_way];
  assign probe_hit = rd_vld[probe_way] && (sel_tag == lk_tag);

  assign accept    = (state_q == ST_IDLE) && req_valid_i;
  assign fill_done = (state_q == ST_FILL) && mem_ack_i;
  assign upd_en    = (accept && probe_hit) || ((state_q == ST_ALT) && probe_hit) || fill_done;
  assign upd_way   = (state_q == ST_FILL) ? victim_q : probe_way;

  wp_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (lk_idx),
    .rd_tag_o (rd_tag),
    .rd_vld_o (rd_vld),
    .wr_en_i  (fill_done),
    .wr_way_i (victim_q),
    .wr_idx_i (lk_idx),
    .wr_tag_i (lk_tag)
  );

  wp_data_array #(.SETS(SETS), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rd_idx_i  (lk_idx),
    .rd_way_i  (probe_way),
    .rd_data_o (rd_data),
    .wr_en_i   (fill_done),
    .wr_way_i  (victim_q),
    .wr_idx_i  (lk_idx),
    .wr_data_i (mem_data_i)
  );

  wp_pred #(.SETS(SETS)) u_pred (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx),
    .pred_way_o (pred_way),
    .lru_way_o  (lru_way),
    .upd_en_i   (upd_en),
    .upd_idx_i  (lk_idx),
    .upd_way_i  (upd_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      alt_q    <= 1'b0;
      victim_q <= 1'b0;
      rv_q     <= 1'b0;
      slow_q   <= 1'b0;
      miss_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rv_q   <= 1'b0;
      slow_q <= 1'b0;
      miss_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (probe_hit) begin
            rv_q    <= 1'b1;
            rdata_q <= rd_data;
          end else begin
            addr_q  <= req_addr_i;
            alt_q   <= ~pred_way;
            state_q <= ST_ALT;
          end
        end
        ST_ALT: begin
          if (probe_hit) begin
            rv_q    <= 1'b1;
            slow_q  <= 1'b1;
            rdata_q <= rd_data;
            state_q <= ST_IDLE;
          end else begin
            victim_q <= lru_way;
            state_q  <= ST_FILL;
          end
        end
        ST_FILL: if (mem_ack_i) begin
          rv_q    <= 1'b1;
          miss_q  <= 1'b1;
          rdata_q <= mem_data_i;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stall_o      = (state_q != ST_IDLE);
  assign resp_valid_o = rv_q;
  assign resp_data_o  = rdata_q;
  assign resp_slow_o  = slow_q;
  assign resp_miss_o  = miss_q;
  assign mem_req_o    = (state_q == ST_FILL);
  assign mem_addr_o   = addr_q;

  AST_FAST_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && probe_hit |=> resp_valid_o && !resp_slow_o && !resp_miss_o); // R2
  AST_WAY_MISS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !probe_hit |=> stall_o && !resp_valid_o); // R3
  AST_ALT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALT) |=> (state_q != ST_ALT)); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $onehot0({resp_slow_o, resp_miss_o})); // R3
  AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R4
  AST_MISS_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_miss_o |-> $past(mem_ack_i)); // R4
endmodule

// File: tb/sim_wp_cache.sv
module sim_wp_cache;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int SETS    = 16;
  localparam int IDX_W   = 4;
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic stall, resp_valid, resp_slow, resp_miss, mem_req;
  logic [DATA_W-1:0] resp_data;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  always #5 clk = ~clk;

  wp_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .stall_o(stall), .resp_valid_o(resp_valid), .resp_data_o(resp_data),
    .resp_slow_o(resp_slow), .resp_miss_o(resp_miss),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_data_i(mem_data)
  );

  // Reference model
  bit               m_vld  [2][SETS];
  logic [TAG_W-1:0] m_tag  [2][SETS];
  bit               m_pred [SETS];
  bit               m_lru  [SETS];

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a, a ^ 16'hA5C3};
  endfunction

  // 0 fast hit, 1 second-cycle hit, 2 miss
  function automatic int model_step(input logic [ADDR_W-1:0] a);
    int idx = int'(a[IDX_W-1:0]);
    logic [TAG_W-1:0] t = a[ADDR_W-1:IDX_W];
    bit p = m_pred[idx];
    bit o = ~p;
    if (m_vld[p][idx] && m_tag[p][idx] == t) begin
      m_lru[idx] = o;
      return 0;
    end
    if (m_vld[o][idx] && m_tag[o][idx] == t) begin
      m_pred[idx] = o;
      m_lru[idx] = p;
      return 1;
    end
    begin
      bit v = m_lru[idx];
      m_vld[v][idx] = 1'b1;
      m_tag[v][idx] = t;
      m_pred[idx] = v;
      m_lru[idx] = ~v;
    end
    return 2;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc_total);
      finish_run();
    end
  end

  // One access; measures latency, stall in first cycle, first refill cycle.
  task automatic access(input logic [ADDR_W-1:0] a, input string req);
    int exp_kind, kind, lat, first_req, wait_cnt;
    bit stall1, got, addr_ok, slw, mis;
    logic [DATA_W-1:0] d;
    exp_kind = model_step(a);
    lat = 0; first_req = 0; wait_cnt = 0; got = 0; addr_ok = 1; stall1 = 0;
    slw = 0; mis = 0; d = '0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!got && lat < 40) begin
      @(negedge clk);
      req_valid = 1'b0;
      mem_ack   = 1'b0;
      lat++;
      if (lat == 1) stall1 = stall;
      if (resp_valid) begin
        got = 1; d = resp_data; slw = resp_slow; mis = resp_miss;
      end else if (mem_req) begin
        if (first_req == 0) first_req = lat;
        if (mem_addr != a) addr_ok = 0;
        wait_cnt++;
        if (wait_cnt == MEM_LAT) begin
          mem_ack  = 1'b1;
          mem_data = mem_word(a);
        end
      end
    end
    if (got && lat == 1 && !slw && !mis && !stall1) kind = 0;
    else if (got && lat == 2 && slw && !mis && stall1) kind = 1;
    else if (got && mis && !slw && stall1 && lat == 2 + MEM_LAT &&
             first_req == 2 && addr_ok) kind = 2;
    else kind = 3;
    chk(kind == exp_kind, req, $sformatf("kind addr=%0h lat=%0d", a, lat),
        DATA_W'(kind), DATA_W'(exp_kind));
    chk(got && d == mem_word(a), "R8", $sformatf("data addr=%0h", a), d, mem_word(a));
  endtask

  function automatic string kind_req(input int k);
    return (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
  endfunction

  initial begin
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) begin
        m_vld[w][s] = 0;
        m_tag[w][s] = '0;
      end
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 0;
      m_lru[s] = 0;
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall, "R1", "stall after reset", DATA_W'(stall), 0);
    chk(!resp_valid, "R1", "resp_valid after reset", DATA_W'(resp_valid), 0);
    chk(!mem_req, "R1", "mem_req after reset", DATA_W'(mem_req), 0);

    // Directed: three tags sharing set 5
    access(16'h1235, "R1");  // cold miss, fills way 0
    access(16'h1235, "R6");  // fast after refill
    access(16'h4565, "R4");  // miss, fills way 1
    access(16'h1235, "R3");  // prediction on way 1, found in way 0
    access(16'h1235, "R5");  // fast after slow hit
    access(16'h7895, "R7");  // miss, LRU replaces way 1 (B)
    access(16'h1235, "R3");
    access(16'h4565, "R7");  // B was replaced: miss again
    access(16'h7895, "R7");  // C replaced by B: miss
    access(16'h0a00, "R1");  // untouched set: cold miss

    // Random: four tags over two sets
    void'($urandom(32'd4242));
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      int pk, kk;
      a = ADDR_W'(((32'h20 + ($urandom % 4)) << IDX_W) | (3 + ($urandom % 2)));
      pk = int'(a[IDX_W-1:0]);
      // peek expected kind without changing the model
      begin
        logic [TAG_W-1:0] t = a[ADDR_W-1:IDX_W];
        bit p = m_pred[pk];
        if (m_vld[p][pk] && m_tag[p][pk] == t) kk = 0;
        else if (m_vld[~p][pk] && m_tag[~p][pk] == t) kk = 1;
        else kk = 2;
      end
      access(a, kind_req(kk));
    end

    finish_run();
  end
endmodule